// File: doc/BRIEF.md
# External Multiplexer Decode Sequencer

This block sits in front of an analog-to-digital converter core. It launches one conversion for each accepted request. Some channel numbers point at inputs that reach the converter through an external analog multiplexer. For one of those, the sequencer first drives the multiplexer's three address lines and a one-hot group select. It then waits a programmable number of settling cycles, so the external switch has time to settle. After that it fires a single-cycle start-of-conversion strobe. Once the strobe has gone out, the address lines and the group select fall back to zero without any software action.

A channel outside the external range skips the address phase and the settling wait. Its strobe fires in the first cycle after the request is accepted. The sequencer reports busy from acceptance until the converter's end-of-conversion input is seen. Any request made while busy is dropped. With the default parameters, external channels are numbers 64 to 95, in four groups of eight. For example, channel 71 selects group 0 with address 7.

Top module: `extMuxSeq`

## Requirements
- R1: While reset is held and after its release with no request, busy, the start strobe, the address lines and the group select are all zero.
- R2: A request is accepted at a rising edge where reqValid is high and busy is low. For an accepted channel c in 64..95, the address lines equal (c-64) mod 8 and the group select has only bit (c-64)/8 set (bit 0 for channels 64 to 71), from the cycle after acceptance until the start strobe.
- R3: For an external channel, with D the delay value sampled at acceptance, the start strobe goes high D+1 cycles after the first cycle in which the address is driven. D=0 fires in the next cycle, and D=255 is honoured in full. Later changes to the delay input have no effect on a request in flight.
- R4: For a channel below 64 or above 95, the start strobe goes high in the cycle right after acceptance, and the address lines and the group select stay zero.
- R5: The start strobe is high for exactly one cycle per accepted request.
- R6: In the cycle after the start strobe, the address lines and the group select are zero.
- R7: Busy is high from the cycle after acceptance until the first rising edge after the strobe cycle that samples eocIn high, and low from the next cycle. eocIn before or during the strobe cycle has no effect.
- R8: A request made while busy is ignored: it changes neither the address, the group select, the strobe timing nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Conversion request |
| reqChan | input | 7 | Channel number of the request |
| settleDly | input | 8 | Settling delay in cycles, sampled at acceptance |
| eocIn | input | 1 | End-of-conversion from the converter core |
| busy | output | 1 | Request in progress |
| muxAddr | output | 3 | External multiplexer address lines |
| grpSel | output | 4 | One-hot external group select |
| socPulse | output | 1 | Single-cycle start-of-conversion strobe |

## Verification
The bench targets these corners:

- The zero delay. An off-by-one counter would fire one cycle late, or never wait at all.
- The 255 delay. A narrow or wrapping counter would fire early.
- The range edges 63, 64, 95 and 96. A loose range decode would drive an address for an internal channel, or skip one for an external channel.
- Requests and end-of-conversion pulses during the settling wait, plus a changed delay input after acceptance. A design that re-accepts, reloads or leaves busy early would show a new address, a shifted strobe or busy dropping.

// File: rtl/extMuxSeqPkg.sv
package extMuxSeqPkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETTLE,
    SQ_FIRE,
    SQ_WAIT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture channel decode and delay
    logic count;  // advance settling counter
    logic clear;  // return address and group select to zero
  } seqStrobe_t;

endpackage

// File: rtl/extMuxSeqDp.sv
module extMuxSeqDp
  import extMuxSeqPkg::*;
#(
  parameter int CHAN_W   = 7,
  parameter int ADDR_W   = 3,
  parameter int DLY_W    = 8,
  parameter int NUM_GRP  = 4,
  parameter int EXT_BASE = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CHAN_W-1:0]  reqChan,
  input  logic [DLY_W-1:0]   settleDly,
  input  seqStrobe_t         strb,
  output logic               isExt,
  output logic               cntDone,
  output logic [ADDR_W-1:0]  muxAddr,
  output logic [NUM_GRP-1:0] grpSel
);

  localparam int GRP_W    = $clog2(NUM_GRP);
  localparam int OFF_W    = ADDR_W + GRP_W;
  localparam int EXT_SPAN = NUM_GRP << ADDR_W;
  localparam int TAG_W    = CHAN_W - OFF_W;
  // EXT_BASE must be a multiple of EXT_SPAN, so the range decode is a tag compare
  localparam logic [TAG_W-1:0] EXT_TAG = TAG_W'(EXT_BASE / EXT_SPAN);

  logic [NUM_GRP-1:0] grpNext;
  logic [DLY_W-1:0]   dlyReg;
  logic [DLY_W-1:0]   cnt;

  assign isExt = (reqChan[CHAN_W-1:OFF_W] == EXT_TAG);

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrpDec
    assign grpNext[g] = isExt && (reqChan[OFF_W-1:ADDR_W] == GRP_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxAddr <= '0;
      grpSel  <= '0;
      dlyReg  <= '0;
      cnt     <= '0;
    end else begin
      if (strb.load) begin
        muxAddr <= isExt ? reqChan[ADDR_W-1:0] : '0;
        grpSel  <= grpNext;
        dlyReg  <= settleDly;
        cnt     <= '0;
      end else begin
        if (strb.count) cnt <= cnt + 1'b1;
        if (strb.clear) begin
          muxAddr <= '0;
          grpSel  <= '0;
        end
      end
    end
  end

  assign cntDone = (cnt == dlyReg);

endmodule

// File: rtl/extMuxSeqCtrl.sv
module extMuxSeqCtrl
  import extMuxSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isExt,
  input  logic       cntDone,
  input  logic       eocIn,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       socPulse
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      SQ_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stateNext = isExt ? SQ_SETTLE : SQ_FIRE;
        end
      end
      SQ_SETTLE: begin
        if (cntDone) stateNext  = SQ_FIRE;
        else         strb.count = 1'b1;
      end
      SQ_FIRE: begin
        strb.clear = 1'b1;
        stateNext  = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (eocIn) stateNext = SQ_IDLE;
      end
      default: stateNext = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SQ_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state != SQ_IDLE);
  assign socPulse = (state == SQ_FIRE);

endmodule

// File: rtl/extMuxSeq.sv
module extMuxSeq
  import extMuxSeqPkg::*;
#(
  parameter int CHAN_W   = 7,
  parameter int ADDR_W   = 3,
  parameter int DLY_W    = 8,
  parameter int NUM_GRP  = 4,
  parameter int EXT_BASE = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CHAN_W-1:0]  reqChan,
  input  logic [DLY_W-1:0]   settleDly,
  input  logic               eocIn,
  output logic               busy,
  output logic [ADDR_W-1:0]  muxAddr,
  output logic [NUM_GRP-1:0] grpSel,
  output logic               socPulse
);

  seqStrobe_t strb;
  logic       isExt;
  logic       cntDone;

  extMuxSeqCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .isExt    (isExt),
    .cntDone  (cntDone),
    .eocIn    (eocIn),
    .strb     (strb),
    .busy     (busy),
    .socPulse (socPulse)
  );

  extMuxSeqDp #(
    .CHAN_W   (CHAN_W),
    .ADDR_W   (ADDR_W),
    .DLY_W    (DLY_W),
    .NUM_GRP  (NUM_GRP),
    .EXT_BASE (EXT_BASE)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .reqChan   (reqChan),
    .settleDly (settleDly),
    .strb      (strb),
    .isExt     (isExt),
    .cntDone   (cntDone),
    .muxAddr   (muxAddr),
    .grpSel    (grpSel)
  );

endmodule

// File: rtl/extMuxSeqChk.sv
module extMuxSeqChk #(
  parameter int CHAN_W   = 7,
  parameter int ADDR_W   = 3,
  parameter int NUM_GRP  = 4,
  parameter int EXT_BASE = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [CHAN_W-1:0]  reqChan,
  input logic               eocIn,
  input logic               busy,
  input logic [ADDR_W-1:0]  muxAddr,
  input logic [NUM_GRP-1:0] grpSel,
  input logic               socPulse
);

  localparam int EXT_SPAN = NUM_GRP << ADDR_W;

  logic              chanExt;
  logic [CHAN_W-1:0] chanOff;
  assign chanExt = (int'(reqChan) >= EXT_BASE) && (int'(reqChan) < EXT_BASE + EXT_SPAN);
  assign chanOff = reqChan - CHAN_W'(EXT_BASE);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (muxAddr == '0 && grpSel == '0 && !socPulse));

  p_ext_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && chanExt) |=> (muxAddr == $past(chanOff[ADDR_W-1:0])));

  p_grp_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grpSel));

  p_int_fire_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !chanExt) |=> (socPulse && muxAddr == '0 && grpSel == '0));

  p_soc_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    socPulse |=> !socPulse);

  p_sel_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    socPulse |=> (muxAddr == '0 && grpSel == '0));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !eocIn) |=> busy);

  p_soc_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    socPulse |-> busy);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

endmodule

bind extMuxSeq extMuxSeqChk #(
  .CHAN_W   (CHAN_W),
  .ADDR_W   (ADDR_W),
  .NUM_GRP  (NUM_GRP),
  .EXT_BASE (EXT_BASE)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqChan  (reqChan),
  .eocIn    (eocIn),
  .busy     (busy),
  .muxAddr  (muxAddr),
  .grpSel   (grpSel),
  .socPulse (socPulse)
);

// File: tb/tb_extMuxSeq.sv
`timescale 1ns/1ps
module tb_extMuxSeq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [6:0] reqChan = '0;
  logic [7:0] settleDly = '0;
  logic       eocIn = 1'b0;
  logic       busy;
  logic [2:0] muxAddr;
  logic [3:0] grpSel;
  logic       socPulse;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  extMuxSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .settleDly(settleDly), .eocIn(eocIn), .busy(busy), .muxAddr(muxAddr),
    .grpSel(grpSel), .socPulse(socPulse)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit expExt(int ch);
    return ch >= 64 && ch < 96;
  endfunction

  function automatic int expAddr(int ch);
    return expExt(ch) ? (ch - 64) % 8 : 0;
  endfunction

  function automatic int expGrp(int ch);
    return expExt(ch) ? (1 << ((ch - 64) / 8)) : 0;
  endfunction

  task automatic runReq(int ch, int dly, int eocWait, bit disturb);
    reqChan   = 7'(ch);
    settleDly = 8'(dly);
    reqValid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid  = 1'b0;
    settleDly = ~8'(dly);  // R3: change after acceptance must not matter
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    if (expExt(ch)) begin
      for (int k = 0; k <= dly + 1; k++) begin
        if (k > 0) @(negedge clk);
        if (k == 1) begin reqValid = 1'b0; eocIn = 1'b0; end
        if (k <= dly) begin
          check(muxAddr == 3'(expAddr(ch)), "R2 address", muxAddr, expAddr(ch));
          check(grpSel == 4'(expGrp(ch)), "R2 group", grpSel, expGrp(ch));
          check(socPulse == 1'b0, "R3 strobe early", socPulse, 0);
          check(busy == 1'b1, "R7 R8 busy in settle", busy, 1);
        end else begin
          check(socPulse == 1'b1, "R3 strobe after delay", socPulse, 1);
        end
        if (k == 0 && disturb) begin
          reqValid = 1'b1;
          reqChan  = 7'(ch) ^ 7'h21;
          eocIn    = 1'b1;
        end
      end
    end else begin
      check(socPulse == 1'b1, "R4 internal strobe", socPulse, 1);
      check(muxAddr == 3'd0, "R4 internal address", muxAddr, 0);
      check(grpSel == 4'd0, "R4 internal group", grpSel, 0);
      if (disturb) begin reqValid = 1'b1; reqChan = 7'd71; end
    end
    @(negedge clk);
    reqValid = 1'b0;
    eocIn    = 1'b0;
    check(socPulse == 1'b0, "R5 strobe width", socPulse, 1'b0);
    check(muxAddr == 3'd0, "R6 R8 address cleared", muxAddr, 0);
    check(grpSel == 4'd0, "R6 R8 group cleared", grpSel, 0);
    check(busy == 1'b1, "R7 busy after strobe", busy, 1);
    for (int w = 0; w < eocWait; w++) begin
      @(negedge clk);
      check(busy == 1'b1, "R7 busy until eoc", busy, 1);
      check(socPulse == 1'b0, "R5 no second strobe", socPulse, 0);
    end
    eocIn = 1'b1;
    @(negedge clk);
    eocIn = 1'b0;
    check(busy == 1'b0, "R7 busy drop", busy, 0);
    check(socPulse == 1'b0 && muxAddr == 3'd0, "R1 idle quiet", muxAddr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    check(busy == 1'b0 && socPulse == 1'b0, "R1 reset outputs", busy, 0);
    check(muxAddr == 3'd0 && grpSel == 4'd0, "R1 reset select", muxAddr, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && socPulse == 1'b0 && grpSel == 4'd0, "R1 after release", busy, 0);

    runReq(71, 0, 0, 1'b0);
    runReq(71, 3, 2, 1'b1);
    runReq(64, 255, 1, 1'b1);
    runReq(95, 1, 0, 1'b0);
    runReq(63, 0, 0, 1'b1);
    runReq(96, 2, 3, 1'b0);
    runReq(0, 5, 1, 1'b1);
    runReq(80, 0, 0, 1'b1);

    for (int i = 0; i < 40; i++) begin
      int ch  = int'($urandom_range(127, 0));
      int dly = ($urandom_range(9, 0) == 0) ? 255 : int'($urandom_range(15, 0));
      int ew  = int'($urandom_range(3, 0));
      bit dis = 1'($urandom_range(1, 0));
      if ($urandom_range(1, 0) == 1) ch = 64 + (ch % 32);
      runReq(ch, dly, ew, dis);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule